// File: doc/BRIEF.md
# Multiplexed Seven-Segment Time Display

This block lights a row of eight seven-segment digits from three packed BCD bytes holding hours, minutes and seconds. Only one digit is lit at a time: a shared active-low segment bus carries the pattern for the current position, and a one-hot active-low select bus enables the matching digit. A prescaler divides the system clock into a scan tick, and on every tick the block moves to the next position. The scan is fast enough that the eye sees a steady display.

Each byte supplies two digits: its low nibble is the units digit and its high nibble is the tens digit. Six positions show seconds, minutes and hours. The two spare positions stay dark. Nibble values above nine show as hex letters, so illegal time values are visible rather than hidden. Counting the time and setting it are done elsewhere.

Top module: `seg_scan_display`

## Requirements
- R1: While reset is low, and after its release until the first scan tick, every select line and every segment line is high (all off). The first tick comes TICK_DIV clocks after reset is released, and it lights position 0 without advancing the index.
- R2: After the first tick, each tick moves the lit position from k to k+1, and from 7 back to 0.
- R3: After the first tick, exactly one select line is low, and bit k of `dig_n` being low means position k is lit.
- R4: Positions 0 to 5 show, in this order: seconds units (sec_bcd[3:0]), seconds tens (sec_bcd[7:4]), minutes units (min_bcd[3:0]), minutes tens (min_bcd[7:4]), hours units (hour_bcd[3:0]) and hours tens (hour_bcd[7:4]).
- R5: Positions 6 and 7 drive the segment bus to 7'b1111111.
- R6: Segment bits are active low, with bit 6 = g down to bit 0 = a. The digits 0 to 9 are encoded as 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000.
- R7: Nibbles 10 to 15 show A, b, C, d, E and F, encoded as 0001000, 0000011, 1000110, 0100001, 0000110 and 0001110.
- R8: A change on a BCD input reaches the segment bus one clock later, and the select bus does not change.
- R9: The select bus changes only on tick edges, which are exactly TICK_DIV clocks apart. Segments and select for a new position appear on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hour_bcd | input | 8 | Hours, packed BCD (tens in [7:4]) |
| min_bcd | input | 8 | Minutes, packed BCD |
| sec_bcd | input | 8 | Seconds, packed BCD |
| seg_n | output | 7 | Segment bus, active low, gfedcba |
| dig_n | output | 8 | Digit select, one-hot active low |

## Verification
The bound checker checks these rules on every cycle:
- no more than one select line is low;
- an all-off select bus comes with blank segments;
- every change of select is a one-step rotation, spaced exactly TICK_DIV clocks from the last;
- the spare positions are always blank.

Only the bench scenarios can show the content rules: which nibble of which byte appears at each position, the encoding of all sixteen nibble values, the one-clock path from input to segments, and the timing of the first tick after a reset.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;

   localparam int SEG_W = 7;
   typedef logic [SEG_W-1:0] seg_t;
   localparam seg_t SEG_BLANK = 7'b111_1111;

   // active-low pattern, bit 6 = g ... bit 0 = a
   function automatic seg_t nib_to_seg(input logic [3:0] nib);
      seg_t s;
      case (nib)
         4'h0: s = 7'b100_0000;
         4'h1: s = 7'b111_1001;
         4'h2: s = 7'b010_0100;
         4'h3: s = 7'b011_0000;
         4'h4: s = 7'b001_1001;
         4'h5: s = 7'b001_0010;
         4'h6: s = 7'b000_0010;
         4'h7: s = 7'b111_1000;
         4'h8: s = 7'b000_0000;
         4'h9: s = 7'b001_0000;
         4'hA: s = 7'b000_1000;
         4'hB: s = 7'b000_0011;
         4'hC: s = 7'b100_0110;
         4'hD: s = 7'b010_0001;
         4'hE: s = 7'b000_0110;
         default: s = 7'b000_1110;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sd_prescaler.sv
module sd_prescaler #(
   parameter int TICK_DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = (cnt_q == TERM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/sd_sequencer.sv
module sd_sequencer #(
   parameter int DIGITS = 8,
   localparam int IDX_W = $clog2(DIGITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [IDX_W-1:0] idx_nxt,
   output logic             live_nxt
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DIGITS - 1);

   logic [IDX_W-1:0] idx_q;
   logic             live_q;

   always_comb begin
      idx_nxt  = idx_q;
      live_nxt = live_q;
      if (tick) begin
         live_nxt = 1'b1;
         if (live_q) idx_nxt = (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         live_q <= 1'b0;
      end else begin
         idx_q  <= idx_nxt;
         live_q <= live_nxt;
      end
   end
endmodule

// File: rtl/sd_digit_mux.sv
module sd_digit_mux
   import seg_disp_pkg::*;
#(
   parameter int DIGITS = 8,
   localparam int IDX_W = $clog2(DIGITS)
) (
   input  logic [7:0]       hour_bcd,
   input  logic [7:0]       min_bcd,
   input  logic [7:0]       sec_bcd,
   input  logic [IDX_W-1:0] idx,
   output seg_t             seg
);
   localparam int TIME_POS = 6;

   logic [3:0] nib [TIME_POS];
   seg_t       pos_seg [DIGITS];

   assign nib[0] = sec_bcd[3:0];
   assign nib[1] = sec_bcd[7:4];
   assign nib[2] = min_bcd[3:0];
   assign nib[3] = min_bcd[7:4];
   assign nib[4] = hour_bcd[3:0];
   assign nib[5] = hour_bcd[7:4];

   for (genvar g = 0; g < DIGITS; g++) begin : g_pos
      if (g < TIME_POS) begin : g_time
         assign pos_seg[g] = nib_to_seg(nib[g]);
      end else begin : g_spare
         assign pos_seg[g] = SEG_BLANK;
      end
   end

   assign seg = pos_seg[idx];
endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display
   import seg_disp_pkg::*;
#(
   parameter int TICK_DIV = 50000,
   parameter int DIGITS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        hour_bcd,
   input  logic [7:0]        min_bcd,
   input  logic [7:0]        sec_bcd,
   output logic [SEG_W-1:0]  seg_n,
   output logic [DIGITS-1:0] dig_n
);
   localparam int IDX_W = $clog2(DIGITS);

   if (TICK_DIV < 2) begin : g_bad_div
      $error("seg_scan_display: TICK_DIV must be at least 2");
   end
   if (DIGITS < 6 || DIGITS > 16) begin : g_bad_digits
      $error("seg_scan_display: DIGITS must be between 6 and 16");
   end

   logic             tick;
   logic [IDX_W-1:0] idx_nxt;
   logic             live_nxt;
   seg_t             seg_nxt;
   logic [DIGITS-1:0] sel_nxt;

   sd_prescaler #(.TICK_DIV(TICK_DIV)) i_prescaler (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   sd_sequencer #(.DIGITS(DIGITS)) i_sequencer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .idx_nxt (idx_nxt),
      .live_nxt(live_nxt)
   );

   sd_digit_mux #(.DIGITS(DIGITS)) i_digit_mux (
      .hour_bcd(hour_bcd),
      .min_bcd (min_bcd),
      .sec_bcd (sec_bcd),
      .idx     (idx_nxt),
      .seg     (seg_nxt)
   );

   for (genvar g = 0; g < DIGITS; g++) begin : g_sel
      assign sel_nxt[g] = live_nxt && (idx_nxt == IDX_W'(g));
   end

   // output stage: segments and select share one register edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_n <= SEG_BLANK;
         dig_n <= '1;
      end else begin
         seg_n <= live_nxt ? seg_nxt : SEG_BLANK;
         dig_n <= ~sel_nxt;
      end
   end
endmodule

// File: rtl/sd_scan_checker.sv
module sd_scan_checker #(
   parameter int TICK_DIV = 50000,
   parameter int DIGITS   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [6:0]        seg_n,
   input logic [DIGITS-1:0] dig_n
);
   localparam int GAP_W = $clog2(TICK_DIV) + 1;
   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   logic [DIGITS-1:0] prev_dig;
   logic [GAP_W-1:0]  gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_dig <= '1;
         gap      <= '0;
      end else begin
         prev_dig <= dig_n;
         if (dig_n != prev_dig) gap <= '0;
         else if (gap != GAP_MAX) gap <= gap + 1'b1;
      end
   end

   p_blank_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_n == '1) |-> (seg_n == 7'h7F));

   p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(dig_n) && $past(dig_n) != '1) |->
         (dig_n == {$past(dig_n[DIGITS-2:0]), $past(dig_n[DIGITS-1])}));

   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~dig_n) <= 1);

   p_spare_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_n[6] == 1'b0 || dig_n[7] == 1'b0) |-> (seg_n == 7'h7F));

   p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_n != prev_dig && prev_dig != '1) |-> (gap == GAP_W'(TICK_DIV - 1)));
endmodule

bind seg_scan_display sd_scan_checker #(.TICK_DIV(TICK_DIV), .DIGITS(DIGITS)) i_scan_checker (
   .clk  (clk),
   .rst_n(rst_n),
   .seg_n(seg_n),
   .dig_n(dig_n)
);

// File: tb/test_seg_scan_display.sv
module test_seg_scan_display;
   localparam int DIV = 4;
   localparam int ND  = 8;
   localparam int NV  = 6;
   localparam logic [23:0] VEC [NV] = '{24'h235959, 24'h000000, 24'h123456,
                                        24'h070809, 24'hABCDEF, 24'h194530};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] hour_bcd = '0, min_bcd = '0, sec_bcd = '0;
   logic [6:0] seg_n;
   logic [ND-1:0] dig_n;
   int checks = 0, errors = 0, pos = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   seg_scan_display #(.TICK_DIV(DIV), .DIGITS(ND)) i_seg_scan_display (
      .clk(clk), .rst_n(rst_n), .hour_bcd(hour_bcd), .min_bcd(min_bcd),
      .sec_bcd(sec_bcd), .seg_n(seg_n), .dig_n(dig_n));

   function automatic logic [6:0] exp_code(input logic [3:0] v);
      logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                             7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
      return t[v];
   endfunction

   function automatic logic [6:0] exp_seg(input int p);
      case (p)
         0: return exp_code(sec_bcd[3:0]);
         1: return exp_code(sec_bcd[7:4]);
         2: return exp_code(min_bcd[3:0]);
         3: return exp_code(min_bcd[7:4]);
         4: return exp_code(hour_bcd[3:0]);
         5: return exp_code(hour_bcd[7:4]);
         default: return 7'h7F;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_pos(input string req);
      logic [ND-1:0] ed;
      ed = ~(ND'(1) << pos);
      chk(dig_n == ed, {req, " select"}, 16'(dig_n), 16'(ed));
      chk(seg_n == exp_seg(pos), {req, " segments"}, 16'(seg_n), 16'(exp_seg(pos)));
   endtask

   task automatic step();
      repeat (DIV) @(posedge clk);
      @(negedge clk);
      pos = (pos + 1) % ND;
   endtask

   task automatic startup(input string req);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      chk(dig_n == '1 && seg_n == 7'h7F, {req, " blank before first tick"},
          {1'b0, seg_n, dig_n}, 16'h7FFF);
      @(posedge clk);
      @(negedge clk);
      pos = 0;
      chk_pos({req, " first tick lights position 0"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dig_n == '1, "R1 reset select", 16'(dig_n), 16'hFF);
      chk(seg_n == 7'h7F, "R1 reset segments", 16'(seg_n), 16'h7F);
      startup("R1");

      // table walk: R2 R3 R4 R5 R6 R7 over eight positions per vector
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         hour_bcd = VEC[v][23:16];
         min_bcd  = VEC[v][15:8];
         sec_bcd  = VEC[v][7:0];
         repeat (DIV - 1) @(posedge clk);
         @(negedge clk);
         pos = (pos + 1) % ND;
         chk_pos("R2/R3/R4 table");
         for (int k = 1; k < ND; k++) begin
            step();
            if (pos >= 6) chk_pos("R5 spare blank");
            else if (v == 4) chk_pos("R7 hex letter");
            else chk_pos("R6 digit code");
         end
      end

      // R9: select holds between ticks
      for (int k = 1; k < DIV; k++) begin
         logic [ND-1:0] held;
         held = dig_n;
         @(posedge clk);
         @(negedge clk);
         chk(dig_n == held, "R9 select stable mid-interval", 16'(dig_n), 16'(held));
      end
      @(posedge clk);
      @(negedge clk);
      pos = (pos + 1) % ND;
      chk_pos("R9 change exactly at tick");

      // R8: input change appears one clock later, select unchanged
      while (pos != 0) step();
      sec_bcd = 8'h47;
      @(posedge clk);
      @(negedge clk);
      chk(seg_n == exp_code(4'h7), "R8 segment follows input", 16'(seg_n), 16'(exp_code(4'h7)));
      chk(dig_n == ~ND'(1), "R8 select unchanged", 16'(dig_n), 16'(~ND'(1)));
      repeat (DIV - 1) @(posedge clk);
      @(negedge clk);
      pos = 1;
      chk_pos("R8 next position after input change");
      step();
      step();
      chk_pos("R2 advance");

      // wrap 7 -> 0
      while (pos != 7) step();
      chk_pos("R5 position 7 blank");
      step();
      chk_pos("R2 wrap to position 0");

      // reset mid-scan
      step();
      step();
      rst_n = 1'b0;
      #1;
      chk(dig_n == '1 && seg_n == 7'h7F, "R1 async reset blanks",
          {1'b0, seg_n, dig_n}, 16'h7FFF);
      startup("R1 after mid-scan reset");
      step();
      chk_pos("R2 advance after reset");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule